// File: doc/BRIEF.md
# CAN Test-Mode Register and Pin Mux

This block holds the test-mode register of a CAN controller and steers the signals that pass between the protocol core and the two bus pins. Software writes the register through a simple write port and reads it back combinationally. The mode bits only take a write while the control logic raises `test_en`. When `test_en` is low, every test function is off: the pins and the core behave normally, whatever the stored bits hold.

The core's receive input can be taken from the synchronized receive pin, from its own transmit bit (internal loopback), or from a wired-AND of the two (silent mode). A two-bit override can replace the transmit pin with the sample-point strobe or with a fixed level. Internal loopback takes precedence over external loopback.

Top module: `can_testmux`

## Requirements
- R1: Register bits 31:10 and 2:0 always read as 0, and writing 1s to them changes no read value and no output.
- R2: Bit 9 (RAM direct access), bit 8 (external loopback), bits 6:5 (transmit control), bit 4 (internal loopback) and bit 3 (silent) take the value of `wdata` on a clock edge with `wr_en`=1 and `test_en`=1. The new value reads back from the next cycle on. Writes while `test_en`=0 leave these bits unchanged.
- R3: While `test_en`=0, `can_tx` equals `core_tx`, `core_rx` equals the synchronized receive level, and all four mode flag outputs are 0, whatever the stored bits hold.
- R4: While `test_en`=1, transmit control 01 drives `can_tx` from `sample_pt`, 10 drives 0 (dominant) and 11 drives 1 (recessive). With 00, `can_tx` carries the mode-dependent level set out in R6, R7 and R8.
- R5: Bit 7 is read-only. It shows `can_rx` delayed by a two-flop synchronizer, where 0 means dominant and 1 means recessive. The `core_rx` path uses the same synchronized value.
- R6: With `test_en`=1 and internal loopback set, `core_rx` equals `core_tx`, and `ext_loop` is 0 even when bit 8 is set. With transmit control 00, `can_tx` is 1 if silent is also set and `core_tx` otherwise.
- R7: With `test_en`=1, silent set and internal loopback clear, `can_tx` is 1 under transmit control 00, and `core_rx` is `core_tx` AND the synchronized receive level.
- R8: With `test_en`=1, external loopback set and both internal loopback and silent clear, `ext_loop` is 1, `can_tx` under transmit control 00 equals `core_tx`, and `core_rx` equals the synchronized receive level.
- R9: On reset, all mode bits read 0 and the synchronizer starts at recessive (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register read value |
| test_en | input | 1 | Test enable from the control register |
| core_tx | input | 1 | Transmit bit from the CAN core |
| sample_pt | input | 1 | Sample-point strobe from the core |
| can_rx | input | 1 | Raw receive pin |
| can_tx | output | 1 | Transmit pin |
| core_rx | output | 1 | Receive bit delivered to the core |
| ram_direct | output | 1 | RAM direct access flag |
| ext_loop | output | 1 | External loopback active |
| int_loop | output | 1 | Internal loopback active |
| silent_mode | output | 1 | Silent mode active |

## Verification
The hardest case to reach is a register that still holds active mode bits while `test_en` is low, where writes must bounce off and the pins must still act normally. The stimulus programs each transmit code and each loopback/silent mix with `test_en` high, then drops `test_en` and keeps writing inverted values. Both loopback bits are also set together to show that internal loopback wins. Throughout, `core_tx`, `sample_pt` and `can_rx` toggle at random every cycle, so each routing path carries changing data.

// File: rtl/can_testmux.sv
module can_testmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        test_en,
  input  logic        core_tx,
  input  logic        sample_pt,
  input  logic        can_rx,
  output logic        can_tx,
  output logic        core_rx,
  output logic        ram_direct,
  output logic        ext_loop,
  output logic        int_loop,
  output logic        silent_mode
);

  logic       ram_q, exl_q, lb_q, sil_q;
  logic [1:0] txc_q;
  logic [SYNC_STAGES-1:0] rx_pipe;
  logic       rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= 1'b0;
      exl_q <= 1'b0;
      txc_q <= 2'b00;
      lb_q  <= 1'b0;
      sil_q <= 1'b0;
    end else if (wr_en && test_en) begin
      ram_q <= wdata[9];
      exl_q <= wdata[8];
      txc_q <= wdata[6:5];
      lb_q  <= wdata[4];
      sil_q <= wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_pipe <= '1;
    else        rx_pipe <= {rx_pipe[SYNC_STAGES-2:0], can_rx};
  end

  assign rx_s = rx_pipe[SYNC_STAGES-1];

  assign ram_direct  = test_en & ram_q;
  assign int_loop    = test_en & lb_q;
  assign ext_loop    = test_en & exl_q & ~lb_q;
  assign silent_mode = test_en & sil_q;

  logic tx_base;
  assign tx_base = silent_mode ? 1'b1 : core_tx;

  always_comb begin
    if (!test_en) can_tx = core_tx;
    else begin
      unique case (txc_q)
        2'b00:   can_tx = tx_base;
        2'b01:   can_tx = sample_pt;
        2'b10:   can_tx = 1'b0;
        default: can_tx = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (int_loop)         core_rx = core_tx;
    else if (silent_mode) core_rx = core_tx & rx_s;
    else                  core_rx = rx_s;
  end

  assign rdata = {22'b0, ram_q, exl_q, rx_s, txc_q, lb_q, sil_q, 3'b000};

endmodule

// File: rtl/can_testmux_chk.sv
module can_testmux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        test_en,
  input logic        core_tx,
  input logic        sample_pt,
  input logic        can_rx,
  input logic        can_tx,
  input logic        core_rx,
  input logic        ram_direct,
  input logic        ext_loop,
  input logic        int_loop,
  input logic        silent_mode
);
  localparam logic [31:0] MODE_MASK = 32'h0000_0378;
  logic [1:0] since_rst;
  logic       rx_d1, rx_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      rx_d1 <= 1'b1;
      rx_d2 <= 1'b1;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      rx_d1 <= can_rx;
      rx_d2 <= rx_d1;
    end
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[31:10] == '0) && (rdata[2:0] == '0));

  assert_write_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> ((rdata & MODE_MASK) == ($past(rdata) & MODE_MASK)));

  assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && wr_en) |=> ((rdata & MODE_MASK) == ($past(wdata) & MODE_MASK)));

  assert_normal_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (can_tx == core_tx) && (core_rx == rdata[7]) &&
                 !ram_direct && !ext_loop && !int_loop && !silent_mode);

  assert_force_dom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[6:5] == 2'b10) |-> !can_tx);

  assert_force_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[6:5] == 2'b11) |-> can_tx);

  assert_sample_mon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[6:5] == 2'b01) |-> (can_tx == sample_pt));

  assert_rx_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (rdata[7] == rx_d2));

  assert_int_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[4]) |-> (core_rx == core_tx) && !ext_loop);

  assert_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[3] && !rdata[4] && rdata[6:5] == 2'b00) |-> can_tx);

  assert_ext_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rdata[8] && !rdata[4] && !rdata[3]) |-> ext_loop && (core_rx == rdata[7]));
endmodule

bind can_testmux can_testmux_chk u_chk (.*);

// File: tb/can_testmux_tb.sv
module can_testmux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        test_en = 1'b0;
  logic        core_tx = 1'b1, sample_pt = 1'b0, can_rx = 1'b1;
  logic        can_tx, core_rx, ram_direct, ext_loop, int_loop, silent_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  can_testmux u_dut (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  bit m_ram, m_exl, m_lb, m_sil;
  bit [1:0] m_txc;
  bit rxq[$];

  initial begin rxq.push_back(1'b1); rxq.push_back(1'b1); end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ram, m_exl, m_lb, m_sil} = '0;
      m_txc = 0;
      rxq = {1'b1, 1'b1};
    end else begin
      if (wr_en && test_en) begin
        m_ram = wdata[9]; m_exl = wdata[8]; m_txc = wdata[6:5];
        m_lb = wdata[4]; m_sil = wdata[3];
      end
      rxq.push_back(can_rx);
      void'(rxq.pop_front());
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit rx, etx, erx, eint, eext, esil, eram;
    bit [31:0] erd;
    rx   = rxq[0];
    eint = test_en && m_lb;
    esil = test_en && m_sil;
    eext = test_en && m_exl && !m_lb;
    eram = test_en && m_ram;
    if (!test_en) etx = core_tx;
    else if (m_txc == 1) etx = sample_pt;
    else if (m_txc == 2) etx = 0;
    else if (m_txc == 3) etx = 1;
    else etx = esil ? 1'b1 : core_tx;
    if (eint) erx = core_tx;
    else if (esil) erx = core_tx & rx;
    else erx = rx;
    erd = '0;
    erd[9] = m_ram; erd[8] = m_exl; erd[6:5] = m_txc; erd[4] = m_lb; erd[3] = m_sil;
    check(rdata[31:10] == 0 && rdata[2:0] == 0, "R1 reserved", rdata, 0);
    check((rdata & 32'h378) == erd, rst_n ? "R2 mode bits" : "R9 reset bits", rdata & 32'h378, erd);
    check(rdata[7] === rx, "R5 rx monitor", rdata[7], rx);
    check(can_tx === etx, !test_en ? "R3 can_tx" : (m_txc != 0 ? "R4 can_tx" :
          (eint ? "R6 can_tx" : (esil ? "R7 can_tx" : "R8 can_tx"))), can_tx, etx);
    check(core_rx === erx, !test_en ? "R3 core_rx" : (eint ? "R6 core_rx" :
          (esil ? "R7 core_rx" : "R8 core_rx")), core_rx, erx);
    check({ram_direct, ext_loop, int_loop, silent_mode} === {eram, eext, eint, esil},
          !test_en ? "R3 flags" : (m_lb ? "R6 flags" : "R8 flags"),
          {ram_direct, ext_loop, int_loop, silent_mode}, {eram, eext, eint, esil});
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      compare();
      wr_en = 0;
      core_tx = 1'($urandom);
      sample_pt = 1'($urandom);
      can_rx = 1'($urandom);
    end
  endtask

  task automatic write(bit [31:0] v);
    @(negedge clk);
    cycles++;
    compare();
    wr_en = 1; wdata = v;
    step(1);
  endtask

  function automatic bit [31:0] cfg(int txc, int mode);
    bit [31:0] v;
    v = 32'hFFFF_FC07;
    v[6:5] = 2'(txc);
    v[9] = mode[0];
    case (mode)
      1: v[3] = 1;
      2: v[4] = 1;
      3: begin v[4] = 1; v[3] = 1; end
      4: v[8] = 1;
      5: begin v[8] = 1; v[4] = 1; end
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    // R9: reset state observed while reset is held
    step(3);
    rst_n = 1;
    step(4);
    // R2: writes while test_en is low are dropped
    write(32'hFFFF_FFFF);
    step(3);
    test_en = 1;
    step(2);
    for (int t = 0; t < 4; t++) begin
      for (int m = 0; m < 6; m++) begin
        write(cfg(t, m));
        step(10);
      end
    end
    // stored bits active, test_en cleared: R3 and blocked writes R2
    for (int t = 0; t < 4; t++) begin
      test_en = 1;
      write(cfg(t, 5) | 32'h0000_0208);
      test_en = 0;
      step(6);
      write(~cfg(t, 5));
      step(6);
    end
    test_en = 1;
    write(32'h0000_0000);
    step(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule